// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit general registers of a processor that runs in several operating modes. Part of the register set is physically duplicated per mode. A fast-interrupt mode gets private copies of logical registers 8 to 14. The four other exception modes each get a private stack pointer (13) and link register (14). User and System share one copy of 8 to 14. Every exception mode also keeps its own saved status word.

Logical indices are remapped to physical entries by the current mode. A mode change is therefore a single register update, and it moves no data. The block has two combinational read ports and one clocked write port. It also has a port that writes the current status word, which may change the mode, and a read/write port for the saved status word of the current mode. Reads of the program counter return the stored value plus 8, which matches the pipeline offset seen by executing code.

Top module: `banked_regfile`

## Requirements
- R1: The mode field is status bits [4:0]. The valid encodings are 10000 user, 10001 fast-interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined and 11111 system. A status write with any other value is rejected as a whole.
- R2: In fast-interrupt mode, logical registers 8 through 14 read and write a private bank of seven registers.
- R3: In interrupt, supervisor, abort and undefined mode, only logical 13 and 14 are private to the mode. Logical 8 to 12 come from the shared bank.
- R4: User and system mode use the same registers 8 through 14, so a switch between them changes no visible value.
- R5: Each of the five exception modes has its own saved status word, written through the saved-status port and read back in that mode. In user and system mode has_saved is low, saved writes are ignored and saved_rd_data is zero.
- R6: A read of logical 15 returns the stored value plus 8. A write to logical 15 stores the written value unchanged.
- R7: A status write whose mode equals the current mode replaces the status word and leaves the visible registers unchanged. A write to another valid mode replaces the status word, and from the next cycle reads use the new mode's banks.
- R8: privileged is high in every mode except user.
- R9: A rejected status write leaves the status word unchanged and raises mode_err for exactly the following cycle.
- R10: A read of a register that is written in the same cycle returns the old value. Register and saved-status writes in a cycle use the mode in force before any status write in that same cycle.
- R11: Reset selects supervisor mode with all other status bits zero, and clears every register and every saved status word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A logical index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B logical index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write logical index |
| wr_data | input | 32 | Register write data |
| st_wr_en | input | 1 | Status word write enable |
| st_wr_data | input | 32 | New status word, mode in [4:0] |
| st_q | output | 32 | Current status word |
| sv_wr_en | input | 1 | Saved status write enable |
| sv_wr_data | input | 32 | Saved status write data |
| saved_rd_data | output | 32 | Saved status word of the current mode |
| has_saved | output | 1 | Current mode has a saved status word |
| privileged | output | 1 | Current mode is not user |
| mode_err | output | 1 | One-cycle pulse after a rejected status write |

## Verification
Random traffic mixes register writes across all sixteen indices with status writes that move through all seven modes, so every index is read in each bank mapping. A read that shows another mode's value points to a mapping error, and a read that misses a value written in a sharing mode points to one as well. Mode words drawn from the full 5-bit range add invalid encodings to the traffic, and these test the rejection path apart from real mode changes. Directed sequences cover cases that random traffic reaches only by chance: a value written in supervisor that must vanish in interrupt mode, the fast-interrupt bank hiding register 8, the user/system equivalence, a same-cycle read and write, and the +8 program counter view.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int W = 32,
  parameter int PC_OFFSET = 8,
  parameter logic [4:0] RESET_MODE = 5'b10011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   rd_a_idx,
  output logic [W-1:0] rd_a_data,
  input  logic [3:0]   rd_b_idx,
  output logic [W-1:0] rd_b_data,
  input  logic         wr_en,
  input  logic [3:0]   wr_idx,
  input  logic [W-1:0] wr_data,
  input  logic         st_wr_en,
  input  logic [W-1:0] st_wr_data,
  output logic [W-1:0] st_q,
  input  logic         sv_wr_en,
  input  logic [W-1:0] sv_wr_data,
  output logic [W-1:0] saved_rd_data,
  output logic         has_saved,
  output logic         privileged,
  output logic         mode_err
);
  localparam logic [4:0] MD_USR = 5'b10000;
  localparam logic [4:0] MD_FIQ = 5'b10001;
  localparam logic [4:0] MD_IRQ = 5'b10010;
  localparam logic [4:0] MD_SVC = 5'b10011;
  localparam logic [4:0] MD_ABT = 5'b10111;
  localparam logic [4:0] MD_UND = 5'b11011;
  localparam logic [4:0] MD_SYS = 5'b11111;
  localparam int NPHYS = 32;
  localparam int NSAV  = 5;

  logic [W-1:0] rf  [0:NPHYS-1];
  logic [W-1:0] sav [0:NSAV-1];
  logic [W-1:0] st;
  logic         err_q;
  logic [4:0]   md;

  function automatic logic mode_ok(input logic [4:0] m);
    return m == MD_USR || m == MD_FIQ || m == MD_IRQ || m == MD_SVC ||
           m == MD_ABT || m == MD_UND || m == MD_SYS;
  endfunction

  // 0..7 shared low, 8..14 user high, 15 pc, 16..22 fiq high, 23.. pairs
  function automatic logic [4:0] phys(input logic [4:0] m, input logic [3:0] i);
    logic [4:0] base;
    if (i < 4'd8 || i == 4'd15) return {1'b0, i};
    if (m == MD_FIQ) return 5'd16 + 5'(i - 4'd8);
    if (i < 4'd13) return {1'b0, i};
    case (m)
      MD_IRQ:  base = 5'd23;
      MD_SVC:  base = 5'd25;
      MD_ABT:  base = 5'd27;
      MD_UND:  base = 5'd29;
      default: return {1'b0, i};
    endcase
    return base + 5'(i - 4'd13);
  endfunction

  function automatic logic [3:0] sav_slot(input logic [4:0] m);
    case (m)
      MD_FIQ:  return 4'd0;
      MD_IRQ:  return 4'd1;
      MD_SVC:  return 4'd2;
      MD_ABT:  return 4'd3;
      MD_UND:  return 4'd4;
      default: return 4'd15;
    endcase
  endfunction

  assign md = st[4:0];
  logic [3:0] cur_slot;
  assign cur_slot = sav_slot(md);

  assign rd_a_data = (rd_a_idx == 4'd15) ? rf[15] + W'(PC_OFFSET) : rf[phys(md, rd_a_idx)];
  assign rd_b_data = (rd_b_idx == 4'd15) ? rf[15] + W'(PC_OFFSET) : rf[phys(md, rd_b_idx)];
  assign st_q = st;
  assign has_saved = cur_slot != 4'd15;
  assign saved_rd_data = has_saved ? sav[cur_slot[2:0]] : '0;
  assign privileged = md != MD_USR;
  assign mode_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NPHYS; k++) rf[k] <= '0;
      for (int k = 0; k < NSAV; k++) sav[k] <= '0;
      st    <= W'(RESET_MODE);
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (wr_en) rf[phys(md, wr_idx)] <= wr_data;
      if (sv_wr_en && has_saved) sav[cur_slot[2:0]] <= sv_wr_data;
      if (st_wr_en) begin
        if (mode_ok(st_wr_data[4:0])) st <= st_wr_data;
        else err_q <= 1'b1;
      end
    end
  end

  AST_MODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok(st_q[4:0])); // R1
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en && !mode_ok(st_wr_data[4:0]) |=> mode_err && st_q == $past(st_q)); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> $past(st_wr_en)); // R9
  AST_USER_NO_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    !privileged |-> !has_saved && saved_rd_data == '0); // R5
  AST_PC_BOTH_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 4'd15 && rd_b_idx == 4'd15 |-> rd_a_data == rd_b_data); // R6
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  logic clk = 0, rst_n = 0;
  logic [3:0] rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, st_wr_data, st_q, sv_wr_data, saved_rd_data;
  logic wr_en, st_wr_en, sv_wr_en, has_saved, privileged, mode_err;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  banked_regfile u0 (.clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .st_q(st_q),
    .sv_wr_en(sv_wr_en), .sv_wr_data(sv_wr_data), .saved_rd_data(saved_rd_data),
    .has_saved(has_saved), .privileged(privileged), .mode_err(mode_err));

  logic [31:0] m_low [8];
  logic [31:0] m_usr [7];
  logic [31:0] m_fiq [7];
  logic [31:0] m_pair [4][2];
  logic [31:0] m_sav [5];
  logic [31:0] m_pc, m_st;
  bit m_err;
  logic [4:0] modes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};

  function automatic bit valid_mode(input logic [4:0] m);
    foreach (modes[k]) if (modes[k] == m) return 1;
    return 0;
  endfunction
  function automatic int pair_of(input logic [4:0] m);
    case (m) 5'b10010: return 0; 5'b10011: return 1; 5'b10111: return 2; 5'b11011: return 3;
      default: return -1; endcase
  endfunction
  function automatic int sav_of(input logic [4:0] m);
    if (m == 5'b10001) return 0;
    if (pair_of(m) >= 0) return pair_of(m) + 1;
    return -1;
  endfunction
  function automatic logic [31:0] exp_rd(input logic [3:0] i);
    logic [4:0] m = m_st[4:0];
    if (i == 15) return m_pc + 32'd8;
    if (i < 8) return m_low[i];
    if (m == 5'b10001) return m_fiq[i-8];
    if (i >= 13 && pair_of(m) >= 0) return m_pair[pair_of(m)][i-13];
    return m_usr[i-8];
  endfunction
  function automatic string tag_of(input logic [3:0] i);
    logic [4:0] m = m_st[4:0];
    if (i == 15) return "R6";
    if (i < 8) return "R10";
    if (m == 5'b10001) return "R2";
    if (pair_of(m) >= 0) return "R3";
    return "R4";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic idle();
    wr_en = 0; st_wr_en = 0; sv_wr_en = 0; wr_idx = 0; wr_data = 0;
    st_wr_data = 0; sv_wr_data = 0; rd_a_idx = 0; rd_b_idx = 0;
  endtask

  task automatic model_update();
    logic [4:0] m = m_st[4:0];
    m_err = 0;
    if (wr_en) begin
      if (wr_idx == 15) m_pc = wr_data;
      else if (wr_idx < 8) m_low[wr_idx] = wr_data;
      else if (m == 5'b10001) m_fiq[wr_idx-8] = wr_data;
      else if (wr_idx >= 13 && pair_of(m) >= 0) m_pair[pair_of(m)][wr_idx-13] = wr_data;
      else m_usr[wr_idx-8] = wr_data;
    end
    if (sv_wr_en && sav_of(m) >= 0) m_sav[sav_of(m)] = sv_wr_data;
    if (st_wr_en) begin
      if (valid_mode(st_wr_data[4:0])) m_st = st_wr_data; else m_err = 1;
    end
  endtask

  task automatic cycle();
    logic [31:0] es;
    #1;
    chk(rd_a_data === exp_rd(rd_a_idx), tag_of(rd_a_idx), rd_a_data, exp_rd(rd_a_idx));
    chk(rd_b_data === exp_rd(rd_b_idx), tag_of(rd_b_idx), rd_b_data, exp_rd(rd_b_idx));
    chk(st_q === m_st, "R7", st_q, m_st);
    chk(privileged === (m_st[4:0] != 5'b10000), "R8", 32'(privileged), 32'(m_st[4:0] != 5'b10000));
    chk(has_saved === (sav_of(m_st[4:0]) >= 0), "R5", 32'(has_saved), 32'(sav_of(m_st[4:0]) >= 0));
    es = (sav_of(m_st[4:0]) >= 0) ? m_sav[sav_of(m_st[4:0])] : 32'd0;
    chk(saved_rd_data === es, "R5", saved_rd_data, es);
    chk(mode_err === m_err, "R9", 32'(mode_err), 32'(m_err));
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [4:0] m);
    idle(); st_wr_en = 1; st_wr_data = {27'd0, m}; cycle(); idle();
    chk(st_q[4:0] === m, "R1", 32'(st_q[4:0]), 32'(m));
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    idle(); wr_en = 1; wr_idx = i; wr_data = d; cycle(); idle();
  endtask

  task automatic rd_expect(input logic [3:0] i, input logic [31:0] e, input string tag);
    idle(); rd_a_idx = i; #1;
    chk(rd_a_data === e, tag, rd_a_data, e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    idle();
    foreach (m_low[k]) m_low[k] = 0;
    foreach (m_usr[k]) begin m_usr[k] = 0; m_fiq[k] = 0; end
    foreach (m_pair[a, b]) m_pair[a][b] = 0;
    foreach (m_sav[k]) m_sav[k] = 0;
    m_pc = 0; m_st = 32'h13; m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk(st_q === 32'h13, "R11", st_q, 32'h13);
    for (int i = 0; i < 15; i++) rd_expect(4'(i), 32'd0, "R11");
    rd_expect(4'd15, 32'd8, "R11");
    chk(saved_rd_data === 0, "R11", saved_rd_data, 0);

    // R3: supervisor private r13, shared r8
    wr(4'd13, 32'hAAAA0013); wr(4'd8, 32'h88880000);
    set_mode(5'b10010);
    rd_expect(4'd13, 32'd0, "R3");
    rd_expect(4'd8, 32'h88880000, "R3");
    // R2: fiq hides r8
    set_mode(5'b10001);
    rd_expect(4'd8, 32'd0, "R2");
    wr(4'd14, 32'hF14F14F1);
    set_mode(5'b10011);
    rd_expect(4'd13, 32'hAAAA0013, "R3");
    rd_expect(4'd14, 32'd0, "R2");
    // R4: user/system share
    set_mode(5'b10000);
    wr(4'd12, 32'h12121212); wr(4'd14, 32'h14141414);
    set_mode(5'b11111);
    rd_expect(4'd14, 32'h14141414, "R4");
    rd_expect(4'd12, 32'h12121212, "R4");
    // R5: saved ignored in system
    idle(); sv_wr_en = 1; sv_wr_data = 32'hDEADBEEF; cycle(); idle();
    chk(saved_rd_data === 0, "R5", saved_rd_data, 0);
    // R6: pc raw write, +8 read
    wr(4'd15, 32'h00001000);
    rd_expect(4'd15, 32'h00001008, "R6");
    // R10: collision returns old
    idle(); wr_en = 1; wr_idx = 4'd5; wr_data = 32'h55; rd_a_idx = 4'd5; #1;
    chk(rd_a_data === 32'd0, "R10", rd_a_data, 0);
    cycle(); idle();
    rd_expect(4'd5, 32'h55, "R10");
    // R7: same-mode write keeps registers
    idle(); st_wr_en = 1; st_wr_data = 32'hF000001F; cycle(); idle();
    rd_expect(4'd14, 32'h14141414, "R7");
    chk(st_q === 32'hF000001F, "R7", st_q, 32'hF000001F);
    // R9: invalid mode
    idle(); st_wr_en = 1; st_wr_data = 32'h00000005; cycle(); idle();
    chk(mode_err === 1'b1, "R9", 32'(mode_err), 1);
    chk(st_q === 32'hF000001F, "R9", st_q, 32'hF000001F);
    cycle();
    chk(mode_err === 1'b0, "R9", 32'(mode_err), 0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      idle();
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      wr_en = ($urandom % 2) == 0; wr_idx = 4'($urandom); wr_data = $urandom;
      sv_wr_en = ($urandom % 4) == 0; sv_wr_data = $urandom;
      st_wr_en = ($urandom % 5) == 0;
      st_wr_data = {$urandom} & 32'hFFFFFFE0;
      if ($urandom % 6 == 0) st_wr_data[4:0] = 5'($urandom);
      else st_wr_data[4:0] = modes[$urandom % 7];
      cycle();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule